// File: doc/BRIEF.md
# Axis-Aligned Line Overlay Stage

This stage sits in a chain of object stages that a stream of pixel chunks passes through in raster order. Each chunk carries a fixed number of one-bit pixels. The stage adds one single-pixel-wide line, either horizontal or vertical, to the chunks as they go past. It returns each chunk one clock later, with its line pixels ORed in. No frame buffer is involved. The stage works out where the stream is on the screen by counting chunks and lines, using the frame-start and line-start flags that travel with the chunks.

The line is described by a signed origin, an orientation bit and a length. These values are sampled only on the frame-start chunk and hold for the rest of that frame. On each covered line, a vertical line lights one bit in the chunk that holds its column. A horizontal line lights every bit of the chunks that lie wholly inside its span. Where the span starts or stops inside a chunk, only the bits in that span are lit. A line whose origin lies above or left of the screen starts drawing at its first visible pixel. Nothing is drawn beyond the screen width or height.

Top module: `line_overlay`

## Requirements
- R1: Every input chunk with `in_valid` high appears on the outputs exactly one cycle later, with `out_valid` high and the same line-start and frame-start flags. A cycle with `in_valid` low gives `out_valid` low one cycle later. `out_valid` is low after reset.
- R2: The output pixels are the input pixels ORed with the line mask, so bits that are already set stay set. Bit i of the k-th chunk on a line is screen column k*PIX+i, and bit 0 is the leftmost pixel.
- R3: A chunk with the frame-start flag is chunk 0 of line 0. A chunk with the line-start flag (and no frame-start flag) is chunk 0 of the next line. Any other chunk is the next chunk on the same line. Before the first frame-start chunk after reset, nothing is drawn.
- R4: When the orientation bit is 1 (vertical), each line from y to y+len-1 gets exactly one bit set, at column x, and nothing else changes.
- R5: When the orientation bit is 0 (horizontal), a chunk on line y whose columns all lie in [x, x+len) gets all of its bits set.
- R6: For a horizontal line, a chunk on line y that the span only partly covers gets only the bits of the covered columns set.
- R7: The origin is signed two's complement. Parts of the line above or left of the screen are skipped, and drawing starts at the first visible pixel. No bit is set in a chunk at index SCR_W or beyond, or on a line at index SCR_H or beyond.
- R8: With `en` low, or with a length of zero, chunks pass through unchanged.
- R9: The configuration inputs are sampled on a valid frame-start chunk and apply from that chunk until the next one. Changes made at any other time have no effect on the drawing.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low synchronous reset |
| en | input | 1 | Drawing enable; low makes the stage transparent |
| cfg_x | input | CW | Origin column, two's complement |
| cfg_y | input | CW | Origin line, two's complement |
| cfg_vert | input | 1 | 1 = vertical line, 0 = horizontal line |
| cfg_len | input | LW | Line length in pixels |
| in_valid | input | 1 | Input chunk valid |
| in_sol | input | 1 | Input chunk is the first chunk of a line |
| in_sof | input | 1 | Input chunk is the first chunk of a frame |
| in_pix | input | PIX | Input pixels, bit 0 leftmost |
| out_valid | output | 1 | Output chunk valid |
| out_sol | output | 1 | Line-start flag of the output chunk |
| out_sof | output | 1 | Frame-start flag of the output chunk |
| out_pix | output | PIX | Output pixels with the line ORed in |

## Verification
The bench builds the stage with PIX=4 on a screen 6 chunks wide and 5 lines tall, with 8-bit coordinates and 6-bit lengths. At this size a short line already starts and stops inside chunks, covers whole chunks in between, runs past both the right edge and the bottom edge, and starts from a negative origin, all within a few dozen chunks. Some frames send extra chunks beyond the sixth on a line and extra lines beyond the fifth, to check that clipping holds there. Idle cycles between chunks and mid-frame configuration changes check that the position tracking and configuration sampling depend only on the flags.

// File: rtl/line_overlay.sv
module line_overlay #(
  parameter int PIX   = 8,
  parameter int SCR_W = 80,
  parameter int SCR_H = 480,
  parameter int CW    = 12,
  parameter int LW    = 11
) (
  input  logic           clk,
  input  logic           rst_n,
  input  logic           en,
  input  logic [CW-1:0]  cfg_x,
  input  logic [CW-1:0]  cfg_y,
  input  logic           cfg_vert,
  input  logic [LW-1:0]  cfg_len,
  input  logic           in_valid,
  input  logic           in_sol,
  input  logic           in_sof,
  input  logic [PIX-1:0] in_pix,
  output logic           out_valid,
  output logic           out_sol,
  output logic           out_sof,
  output logic [PIX-1:0] out_pix
);
  localparam int CCW = $clog2(SCR_W + 1);
  localparam int LCW = $clog2(SCR_H + 1);
  localparam int SW  = CW + 2;
  localparam logic [CCW-1:0] WMAX = CCW'(SCR_W);
  localparam logic [LCW-1:0] HMAX = LCW'(SCR_H);
  localparam logic signed [SW-1:0] PIXS = SW'(PIX);

  logic [CCW-1:0] cur_c, pos_c;
  logic [LCW-1:0] cur_l, pos_l;
  logic [CW-1:0]  x_r, y_r, ex, ey;
  logic [LW-1:0]  len_r, elen;
  logic           v_r, ev, ld, onscr, hrow, vrow;
  logic signed [SW-1:0] xs, ys, xe, ye, lx, row, cbase;
  logic [PIX-1:0] mask;

  assign ld   = in_valid & in_sof;
  assign ex   = ld ? cfg_x    : x_r;
  assign ey   = ld ? cfg_y    : y_r;
  assign ev   = ld ? cfg_vert : v_r;
  assign elen = ld ? cfg_len  : len_r;

  assign pos_c = (in_sol | in_sof) ? '0 : (cur_c == WMAX) ? cur_c : cur_c + 1'b1;
  assign pos_l = in_sof ? '0 : !in_sol ? cur_l : (cur_l == HMAX) ? cur_l : cur_l + 1'b1;

  assign xs    = {{2{ex[CW-1]}}, ex};
  assign ys    = {{2{ey[CW-1]}}, ey};
  assign lx    = {{(SW-LW){1'b0}}, elen};
  assign xe    = xs + lx;
  assign ye    = ys + lx;
  assign row   = {{(SW-LCW){1'b0}}, pos_l};
  assign cbase = $signed({{(SW-CCW){1'b0}}, pos_c}) * PIXS;

  assign onscr = in_valid & en & (pos_c < WMAX) & (pos_l < HMAX);
  assign hrow  = !ev && (row == ys);
  assign vrow  = ev && (row >= ys) && (row < ye);

  for (genvar i = 0; i < PIX; i++) begin : g_bit
    logic signed [SW-1:0] col;
    assign col = cbase + $signed(SW'(i));
    assign mask[i] = onscr & ((hrow & (col >= xs) & (col < xe)) | (vrow & (col == xs)));
  end

  always_ff @(posedge clk) begin
    if (!rst_n) begin
      cur_c <= WMAX;  cur_l <= HMAX;
      x_r <= '0;  y_r <= '0;  v_r <= 1'b0;  len_r <= '0;
      out_valid <= 1'b0;  out_sol <= 1'b0;  out_sof <= 1'b0;  out_pix <= '0;
    end else begin
      if (in_valid) begin
        cur_c <= pos_c;
        cur_l <= pos_l;
      end
      if (ld) begin
        x_r <= cfg_x;  y_r <= cfg_y;  v_r <= cfg_vert;  len_r <= cfg_len;
      end
      out_valid <= in_valid;
      out_sol   <= in_valid & in_sol;
      out_sof   <= in_valid & in_sof;
      out_pix   <= in_pix | mask;
    end
  end

  p_delay_r1: assert property (@(posedge clk) disable iff (!rst_n)
    in_valid |=> out_valid && out_sol == $past(in_sol) && out_sof == $past(in_sof));
  p_idle_r1: assert property (@(posedge clk) disable iff (!rst_n)
    !in_valid |=> !out_valid);
  p_or_keep_r2: assert property (@(posedge clk) disable iff (!rst_n)
    in_valid |=> (out_pix & $past(in_pix)) == $past(in_pix));
  p_vert_single_r4: assert property (@(posedge clk) disable iff (!rst_n)
    (in_valid && ev) |=> $countones(out_pix & ~$past(in_pix)) <= 1);
  p_clip_r7: assert property (@(posedge clk) disable iff (!rst_n)
    (in_valid && (pos_c >= WMAX || pos_l >= HMAX)) |=> out_pix == $past(in_pix));
  p_pass_r8: assert property (@(posedge clk) disable iff (!rst_n)
    (in_valid && (!en || elen == '0)) |=> out_pix == $past(in_pix));
  p_cfg_hold_r9: assert property (@(posedge clk) disable iff (!rst_n)
    !ld |=> $stable(x_r) && $stable(y_r) && $stable(v_r) && $stable(len_r));
endmodule

// File: tb/sim_line_overlay.sv
module sim_line_overlay;
  localparam int CLK_P = 10;
  localparam int PIX = 4, W = 6, H = 5, CW = 8, LW = 6;

  logic clk = 0, rst_n = 0, en = 0;
  logic [CW-1:0] cfg_x = 0, cfg_y = 0;
  logic cfg_vert = 0;
  logic [LW-1:0] cfg_len = 0;
  logic in_valid = 0, in_sol = 0, in_sof = 0;
  logic [PIX-1:0] in_pix = 0;
  logic out_valid, out_sol, out_sof;
  logic [PIX-1:0] out_pix;

  line_overlay #(.PIX(PIX), .SCR_W(W), .SCR_H(H), .CW(CW), .LW(LW)) u0 (
    .clk(clk), .rst_n(rst_n), .en(en), .cfg_x(cfg_x), .cfg_y(cfg_y),
    .cfg_vert(cfg_vert), .cfg_len(cfg_len), .in_valid(in_valid),
    .in_sol(in_sol), .in_sof(in_sof), .in_pix(in_pix), .out_valid(out_valid),
    .out_sol(out_sol), .out_sof(out_sof), .out_pix(out_pix));

  always #(CLK_P/2) clk = ~clk;

  int nchk = 0, nfail = 0;
  bit fin = 0;
  logic [PIX+1:0] exq[$];
  string tq[$];

  int bc = W, bl = H;
  int mx = 0, my = 0, ml = 0;
  bit mv = 0;

  function automatic logic [PIX-1:0] model_mask();
    logic [PIX-1:0] m = '0;
    if (!en || bc >= W || bl >= H) return m;
    for (int i = 0; i < PIX; i++) begin
      int col = bc * PIX + i;
      if (mv) m[i] = (bl >= my) && (bl < my + ml) && (col == mx);
      else    m[i] = (bl == my) && (col >= mx) && (col < mx + ml);
    end
    return m;
  endfunction

  task automatic send(input bit sol, input bit sof, input logic [PIX-1:0] pix, input string tag);
    @(negedge clk);
    in_valid = 1; in_sol = sol; in_sof = sof; in_pix = pix;
    if (sof) begin
      bc = 0; bl = 0;
      mx = $signed(cfg_x); my = $signed(cfg_y); mv = cfg_vert; ml = cfg_len;
    end else if (sol) begin
      bc = 0; if (bl < H) bl++;
    end else if (bc < W) bc++;
    exq.push_back({sol, sof, pix | model_mask()});
    tq.push_back(tag);
  endtask

  task automatic idle(input int n);
    for (int k = 0; k < n; k++) begin
      @(negedge clk);
      in_valid = 0; in_sol = 0; in_sof = 0;
    end
  endtask

  task automatic frame(input int lines, input int chunks, input bit mut, input bit gaps, input string tag);
    for (int l = 0; l < lines; l++) begin
      if (mut && l == 1) begin
        cfg_x = cfg_x + 8'd3; cfg_y = cfg_y + 8'd1; cfg_vert = ~cfg_vert; cfg_len = cfg_len + 6'd4;
      end
      for (int c = 0; c < chunks; c++) begin
        send(c == 0 && l > 0, c == 0 && l == 0, ((l + c) % 3 == 0) ? 4'b1000 : 4'b0000, tag);
        if (gaps && c == 2) idle(1);
      end
    end
    idle(2);
  endtask

  task automatic setcfg(input int x, input int y, input bit v, input int len);
    cfg_x = CW'(x); cfg_y = CW'(y); cfg_vert = v; cfg_len = LW'(len);
  endtask

  always @(negedge clk) begin
    if (rst_n && out_valid && !fin) begin
      if (exq.size() == 0) begin
        nfail++;
        $display("FAIL R1: unexpected output chunk got %h exp none", out_pix);
      end else begin
        logic [PIX+1:0] e;
        string t;
        e = exq.pop_front();
        t = tq.pop_front();
        nchk++;
        if ({out_sol, out_sof, out_pix} !== e) begin
          nfail++;
          $display("FAIL %s: got %b exp %b", t, {out_sol, out_sof, out_pix}, e);
        end
      end
    end
  end

  initial begin
    #(CLK_P * 20000);
    if (!fin) begin
      nfail++;
      $display("FAIL watchdog: got hung exp done");
      fin = 1;
      $display("*** SUMMARY: %0d compared / %0d mismatched ***", nchk, nfail);
      $finish;
    end
  end

  initial begin
    repeat (3) @(negedge clk);
    nchk++;
    if (out_valid !== 1'b0) begin
      nfail++;
      $display("FAIL R1: reset out_valid got %b exp 0", out_valid);
    end
    rst_n = 1;
    en = 1;
    setcfg(5, 1, 0, 10);
    // R3: chunks before the first frame start are untouched
    send(0, 0, 4'b0001, "R3");
    send(1, 0, 4'b0000, "R3");
    send(0, 0, 4'b0000, "R3");
    idle(1);
    // R5 R6 R2: horizontal cols 5..14 on line 1
    frame(H, W, 0, 1, "R5_R6");
    // R4: vertical at column 9, lines 2..3
    setcfg(9, 2, 1, 2);
    frame(H, W, 0, 0, "R4");
    // R9: mid-frame config changes ignored
    setcfg(2, 3, 0, 7);
    frame(H, W, 1, 0, "R9");
    // R7: negative origin, horizontal cols 0..2
    setcfg(-3, 0, 0, 6);
    frame(H, W + 2, 0, 0, "R7");
    // R7: right edge clip past column 23 with extra chunks
    setcfg(20, 4, 0, 20);
    frame(H + 2, W + 2, 0, 0, "R7");
    // R7: vertical from above the screen and past the bottom
    setcfg(0, -2, 1, 40);
    frame(H + 2, W, 0, 1, "R7");
    setcfg(23, -1, 1, 3);
    frame(H, W, 0, 0, "R7_R4");
    // R8: enable low, then zero length
    setcfg(1, 1, 0, 20);
    en = 0;
    frame(H, W, 0, 0, "R8");
    en = 1;
    setcfg(4, 2, 1, 0);
    frame(H, W, 0, 0, "R8");
    // R2: full-width line over preset bits
    setcfg(0, 3, 0, 24);
    frame(H, W, 0, 1, "R2_R5");
    idle(4);
    nchk++;
    if (exq.size() != 0) begin
      nfail++;
      $display("FAIL R1: outstanding chunks got %0d exp 0", exq.size());
    end
    fin = 1;
    $display("*** SUMMARY: %0d compared / %0d mismatched ***", nchk, nfail);
    $finish;
  end
endmodule